// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block keeps the atomic-update reservations for a small set of hardware thread contexts. A load-reserve request records, per thread, the 128-byte line it touched and whether it was a word or a doubleword reservation. A later word store-conditional from that thread commits to memory only if the reservation is still intact, is word-sized and covers the line of the store. The block resolves the store's effective address from a base and an index operand, drives a byte-lane memory write port and returns a four-bit condition result telling software whether to retry.

Reservations are lost when another agent stores anywhere in the reserved line, when the owning thread is context-switched, when another thread's store-conditional to the same line commits, and after every store-conditional of the owning thread. A store-conditional to an address that is not word aligned raises an alignment fault instead of completing. All outputs are registered and appear one clock after the request.

Top module: `lrsc_monitor`

## Requirements
- R1: The effective address is `sc_index` when `sc_base_zero` is 1, otherwise `sc_base + sc_index`, with the sum cut to its low 32 bits; on a committed store `mem_addr` equals it.
- R2: A store-conditional commits only when its thread holds a valid, word-width reservation whose line tag (address with its low 7 bits cleared) equals the store's line tag; a commit pulses `mem_we` for one cycle and sets EQ.
- R3: The write data is the low 32 bits of `sc_data` in big-endian lane order: lane k (`mem_wdata[8k+7:8k]`) carries the byte for address ea+k, so lane 0 holds `sc_data[31:24]`; bits 63..32 of `sc_data` have no effect.
- R4: `cr_field` is {LT,GT,EQ,SO} from bit 3 down to bit 0; after every aligned store-conditional LT=GT=0, EQ tells success, SO copies `so_in` of the request cycle, and a failed one leaves `mem_we` low.
- R5: Every store-conditional, committed, failed or faulting, clears its own thread's reservation and width, so a second one without a new reserve fails.
- R6: A store-conditional against a doubleword reservation (`rsv_dword`=1) fails even when the line matches.
- R7: The reservation granule is the aligned 128-byte line: any word in the reserved line may commit, a word in the next line fails.
- R8: A snoop to any byte of a reserved line drops that reservation, also when it arrives in the same cycle as the store-conditional; a snoop outside the line has no effect, and a reserve arriving in the same cycle as a matching snoop is kept.
- R9: A store-conditional whose address has nonzero low two bits pulses `align_fault` for one cycle, performs no write and leaves `cr_field` unchanged.
- R10: `ctx_clear[t]` drops thread t's reservation, takes priority over a reserve of that thread in the same cycle, and leaves other threads untouched.
- R11: A new reserve on a thread replaces its previous reservation; a reserve and a store-conditional of the same thread in one cycle leave no reservation.
- R12: A committed store-conditional drops every other thread's reservation on the same line and keeps those on other lines.
- R13: After reset `mem_we`=0, `align_fault`=0, `cr_field`=0 and no thread holds a reservation; results appear on the clock edge after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsv_valid | input | 1 | Load-reserve request |
| rsv_tid | input | TID_W | Thread of the reserve |
| rsv_addr | input | ADDR_W | Effective address of the reserve |
| rsv_dword | input | 1 | 1 = doubleword reservation, 0 = word |
| sc_valid | input | 1 | Word store-conditional request |
| sc_tid | input | TID_W | Thread of the store-conditional |
| sc_base_zero | input | 1 | Base register field is zero |
| sc_base | input | DATA_W | Base operand value |
| sc_index | input | DATA_W | Index operand value |
| sc_data | input | DATA_W | Source register value |
| so_in | input | 1 | Summary-overflow bit copied into SO |
| snoop_valid | input | 1 | Store by another agent observed |
| snoop_addr | input | ADDR_W | Address of that store |
| ctx_clear | input | NUM_THREADS | Per-thread context-switch drop |
| mem_we | output | 1 | Memory write enable (one-cycle pulse) |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 32 | Write data, lane k for byte ea+k |
| cr_field | output | 4 | {LT,GT,EQ,SO} condition result |
| align_fault | output | 1 | Misaligned store-conditional (one-cycle pulse) |

## Verification
The hardest situations to reach are the same-cycle collisions: a snoop or a context clear landing in the very cycle a store-conditional is evaluated, a reserve meeting a snoop of its own line, and a commit by one thread silently stripping another thread's reservation. Directed sequences place each of these on a single clock, and a long random phase then confines addresses to two adjacent lines and three threads so that reserves, snoops, commits and misaligned stores collide constantly while a behavioural reference model predicts every output each cycle.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

   typedef enum logic [3:0] {
      WID_NONE  = 4'd0,
      WID_WORD  = 4'd4,
      WID_DWORD = 4'd8
   } resv_width_e;

   typedef struct packed {
      logic lt;
      logic gt;
      logic eq;
      logic so;
   } cond_t;

endpackage

// File: rtl/lrsc_ea_calc.sv
module lrsc_ea_calc #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 64,
   parameter int LINE_BITS  = 7,
   parameter int ALIGN_BITS = 2,
   localparam int TAG_W     = ADDR_W - LINE_BITS
) (
   input  logic              base_zero,
   input  logic [DATA_W-1:0] base,
   input  logic [DATA_W-1:0] index,
   output logic [ADDR_W-1:0] ea,
   output logic [TAG_W-1:0]  tag,
   output logic              misaligned
);

   logic [DATA_W-1:0] sum;

   always_comb begin
      sum        = (base_zero ? '0 : base) + index;
      ea         = sum[ADDR_W-1:0];
      tag        = ea[ADDR_W-1:LINE_BITS];
      misaligned = |ea[ALIGN_BITS-1:0];
   end

endmodule

// File: rtl/lrsc_resv_slot.sv
module lrsc_resv_slot
   import lrsc_pkg::*;
#(
   parameter int TAG_W = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctx_drop,
   input  logic             own_sc,
   input  logic             load,
   input  logic [TAG_W-1:0] load_tag,
   input  logic             load_dword,
   input  logic             snoop_valid,
   input  logic [TAG_W-1:0] snoop_tag,
   input  logic             peer_commit,
   input  logic [TAG_W-1:0] peer_tag,
   input  logic [TAG_W-1:0] sc_tag,
   output logic             sc_ok
);

   logic        held;
   logic [TAG_W-1:0] held_tag;
   resv_width_e held_wid;
   logic        snoop_hit;
   logic        peer_hit;

   always_comb begin
      snoop_hit = snoop_valid && (snoop_tag == held_tag);
      peer_hit  = peer_commit && (peer_tag == held_tag);
      sc_ok     = held && !ctx_drop && !snoop_hit &&
                  (held_wid == WID_WORD) && (held_tag == sc_tag);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held     <= 1'b0;
         held_tag <= '0;
         held_wid <= WID_NONE;
      end else if (ctx_drop || own_sc) begin
         held     <= 1'b0;
         held_wid <= WID_NONE;
      end else if (load) begin
         held     <= 1'b1;
         held_tag <= load_tag;
         held_wid <= load_dword ? WID_DWORD : WID_WORD;
      end else if (snoop_hit || peer_hit) begin
         held     <= 1'b0;
      end
   end

endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
   import lrsc_pkg::*;
#(
   parameter int NUM_THREADS = 4,
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 64,
   parameter int LINE_BITS   = 7,
   localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
   localparam int TAG_W      = ADDR_W - LINE_BITS,
   localparam int WORD_W     = 32,
   localparam int LANES      = WORD_W / 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rsv_valid,
   input  logic [TID_W-1:0]       rsv_tid,
   input  logic [ADDR_W-1:0]      rsv_addr,
   input  logic                   rsv_dword,
   input  logic                   sc_valid,
   input  logic [TID_W-1:0]       sc_tid,
   input  logic                   sc_base_zero,
   input  logic [DATA_W-1:0]      sc_base,
   input  logic [DATA_W-1:0]      sc_index,
   input  logic [DATA_W-1:0]      sc_data,
   input  logic                   so_in,
   input  logic                   snoop_valid,
   input  logic [ADDR_W-1:0]      snoop_addr,
   input  logic [NUM_THREADS-1:0] ctx_clear,
   output logic                   mem_we,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic [WORD_W-1:0]      mem_wdata,
   output logic [3:0]             cr_field,
   output logic                   align_fault
);

   if (NUM_THREADS < 1) begin : g_bad_threads
      $error("lrsc_monitor: NUM_THREADS must be at least 1");
   end
   if (DATA_W < ADDR_W || DATA_W < WORD_W) begin : g_bad_data
      $error("lrsc_monitor: DATA_W must cover ADDR_W and a word");
   end
   if (LINE_BITS < 2 || LINE_BITS >= ADDR_W) begin : g_bad_line
      $error("lrsc_monitor: LINE_BITS out of range");
   end

   logic [ADDR_W-1:0]      sc_ea;
   logic [TAG_W-1:0]       sc_tag;
   logic                   sc_misaligned;
   logic [NUM_THREADS-1:0] slot_ok;
   logic                   commit;
   logic [WORD_W-1:0]      swapped;

   lrsc_ea_calc #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .LINE_BITS (LINE_BITS),
      .ALIGN_BITS(2)
   ) u_ea (
      .base_zero (sc_base_zero),
      .base      (sc_base),
      .index     (sc_index),
      .ea        (sc_ea),
      .tag       (sc_tag),
      .misaligned(sc_misaligned)
   );

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_slot
      logic own_sc;
      logic load;
      assign own_sc = sc_valid  && (sc_tid  == TID_W'(t));
      assign load   = rsv_valid && (rsv_tid == TID_W'(t));

      lrsc_resv_slot #(.TAG_W(TAG_W)) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .ctx_drop   (ctx_clear[t]),
         .own_sc     (own_sc),
         .load       (load),
         .load_tag   (rsv_addr[ADDR_W-1:LINE_BITS]),
         .load_dword (rsv_dword),
         .snoop_valid(snoop_valid),
         .snoop_tag  (snoop_addr[ADDR_W-1:LINE_BITS]),
         .peer_commit(commit),
         .peer_tag   (sc_tag),
         .sc_tag     (sc_tag),
         .sc_ok      (slot_ok[t])
      );
   end

   assign commit = sc_valid && !sc_misaligned && slot_ok[sc_tid];

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign swapped[8*k +: 8] = sc_data[WORD_W-1-8*k -: 8];
   end

   cond_t cond_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_we      <= 1'b0;
         mem_addr    <= '0;
         mem_wdata   <= '0;
         align_fault <= 1'b0;
         cond_q      <= '0;
      end else begin
         mem_we      <= commit;
         align_fault <= sc_valid && sc_misaligned;
         if (commit) begin
            mem_addr  <= sc_ea;
            mem_wdata <= swapped;
         end
         if (sc_valid && !sc_misaligned) begin
            cond_q <= '{lt: 1'b0, gt: 1'b0, eq: commit, so: so_in};
         end
      end
   end

   assign cr_field = cond_q;

endmodule

// File: rtl/lrsc_monitor_checker.sv
module lrsc_monitor_checker #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sc_valid,
   input logic              so_in,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [3:0]        cr_field,
   input logic              align_fault
);

   // R2: a commit always reports EQ in the same cycle
   assert_we_sets_eq_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> cr_field[1]);

   // R13: a write pulse is always the result of the previous cycle's request
   assert_we_follows_sc_R13: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $past(sc_valid));

   // R9: a fault and a write never happen together
   assert_fault_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && align_fault));

   // R9: a fault keeps the previous condition result
   assert_fault_keeps_cr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      align_fault |-> $stable(cr_field));

   // R9: a fault stems from a request
   assert_fault_follows_sc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      align_fault |-> $past(sc_valid));

   // R9: committed writes are word aligned
   assert_write_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_addr[1:0] == 2'b00));

   // R4: SO copies the summary-overflow input of the request cycle
   assert_so_copied_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sc_valid) && !align_fault) |-> (cr_field[0] == $past(so_in)));

endmodule

bind lrsc_monitor lrsc_monitor_checker #(.ADDR_W(ADDR_W)) u_lrsc_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sc_valid   (sc_valid),
   .so_in      (so_in),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .cr_field   (cr_field),
   .align_fault(align_fault)
);

// File: tb/lrsc_monitor_bench.sv
`timescale 1ns/1ps
module lrsc_monitor_bench;

   localparam int NT = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rsv_valid = 0;
   logic [1:0]  rsv_tid = 0;
   logic [31:0] rsv_addr = 0;
   logic        rsv_dword = 0;
   logic        sc_valid = 0;
   logic [1:0]  sc_tid = 0;
   logic        sc_base_zero = 0;
   logic [63:0] sc_base = 0;
   logic [63:0] sc_index = 0;
   logic [63:0] sc_data = 0;
   logic        so_in = 0;
   logic        snoop_valid = 0;
   logic [31:0] snoop_addr = 0;
   logic [NT-1:0] ctx_clear = 0;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [3:0]  cr_field;
   logic        align_fault;

   always #5 clk = ~clk;

   lrsc_monitor u_lrsc_monitor (
      .clk(clk), .rst_n(rst_n),
      .rsv_valid(rsv_valid), .rsv_tid(rsv_tid), .rsv_addr(rsv_addr), .rsv_dword(rsv_dword),
      .sc_valid(sc_valid), .sc_tid(sc_tid), .sc_base_zero(sc_base_zero),
      .sc_base(sc_base), .sc_index(sc_index), .sc_data(sc_data), .so_in(so_in),
      .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .ctx_clear(ctx_clear),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .cr_field(cr_field), .align_fault(align_fault)
   );

   int    checks = 0;
   int    failures = 0;
   string req = "R13";

   // behavioural reference state
   bit          m_v[NT];
   int unsigned m_line[NT];
   int          m_bytes[NT];
   bit          e_we = 0;
   bit          e_fault = 0;
   bit [31:0]   e_addr = 0;
   bit [31:0]   e_data = 0;
   bit [3:0]    e_cr = 0;

   task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   task automatic model();
      bit [63:0]   sum;
      bit [31:0]   ea;
      bit          ok;
      int unsigned sline;
      e_we = 0;
      e_fault = 0;
      sum = (sc_base_zero ? 64'd0 : sc_base) + sc_index;
      ea = sum[31:0];
      sline = ea >> 7;
      if (sc_valid) begin
         if (ea % 4 != 0) e_fault = 1;
         else begin
            ok = m_v[sc_tid] && !ctx_clear[sc_tid] && m_bytes[sc_tid] == 4 &&
                 m_line[sc_tid] == sline &&
                 !(snoop_valid && (snoop_addr >> 7) == m_line[sc_tid]);
            e_cr = {2'b00, ok, so_in};
            if (ok) begin
               e_we = 1;
               e_addr = ea;
               for (int k = 0; k < 4; k++) e_data[8*k +: 8] = sc_data[31-8*k -: 8];
            end
         end
      end
      for (int t = 0; t < NT; t++) begin
         if (ctx_clear[t] || (sc_valid && sc_tid == t)) begin
            m_v[t] = 0; m_bytes[t] = 0;
         end else if (rsv_valid && rsv_tid == t) begin
            m_v[t] = 1; m_line[t] = rsv_addr >> 7; m_bytes[t] = rsv_dword ? 8 : 4;
         end else if ((snoop_valid && (snoop_addr >> 7) == m_line[t]) ||
                      (e_we && sline == m_line[t])) begin
            m_v[t] = 0;
         end
      end
   endtask

   task automatic compare();
      chk(align_fault == e_fault, {req, " align_fault"}, align_fault, e_fault);
      chk(mem_we == e_we, {req, " mem_we"}, mem_we, e_we);
      if (e_we) begin
         chk(mem_addr == e_addr, {req, " mem_addr"}, mem_addr, e_addr);
         chk(mem_wdata == e_data, {req, " mem_wdata"}, mem_wdata, e_data);
      end
      chk(cr_field == e_cr, {req, " cr_field"}, cr_field, e_cr);
   endtask

   task automatic tick();
      @(posedge clk);
      model();
      @(negedge clk);
      compare();
   endtask

   task automatic idle();
      rsv_valid = 0; sc_valid = 0; snoop_valid = 0; ctx_clear = 0;
   endtask

   task automatic set_rsv(input int t, input bit [31:0] a, input bit dw);
      rsv_valid = 1; rsv_tid = 2'(t); rsv_addr = a; rsv_dword = dw;
   endtask

   task automatic set_sc(input int t, input bit bz, input bit [63:0] b, input bit [63:0] i, input bit [63:0] d);
      sc_valid = 1; sc_tid = 2'(t); sc_base_zero = bz; sc_base = b; sc_index = i; sc_data = d;
   endtask

   task automatic rsv(input int t, input bit [31:0] a, input bit dw);
      set_rsv(t, a, dw); tick(); idle();
   endtask

   task automatic sc(input int t, input bit [31:0] a);
      set_sc(t, 1'b0, 64'd0, {32'd0, a}, 64'hA5A5_A5A5_0102_0304); tick(); idle();
   endtask

   task automatic snoop(input bit [31:0] a);
      snoop_valid = 1; snoop_addr = a; tick(); idle();
   endtask

   initial begin
      for (int t = 0; t < NT; t++) begin m_v[t] = 0; m_line[t] = 0; m_bytes[t] = 0; end
      repeat (3) @(negedge clk);
      // R13: reset state
      chk(mem_we == 0, "R13 reset mem_we", mem_we, 0);
      chk(align_fault == 0, "R13 reset align_fault", align_fault, 0);
      chk(cr_field == 0, "R13 reset cr_field", cr_field, 0);
      rst_n = 1;
      req = "R13"; sc(0, 32'h0000_1000);

      req = "R2"; rsv(0, 32'h1000, 0);
      set_sc(0, 0, 64'h1000, 64'h0, 64'hDEAD_BEEF_1122_3344); tick(); idle();
      chk(cr_field == 4'b0010, "R2 success cr", cr_field, 4'b0010);
      chk(mem_wdata == 32'h4433_2211, "R3 big-endian lanes", mem_wdata, 32'h4433_2211);

      req = "R1"; rsv(1, 32'h2040, 0);
      set_sc(1, 1, 64'hFFFF, 64'h2040, 64'h1); tick(); idle();
      chk(mem_addr == 32'h2040, "R1 base zero", mem_addr, 32'h2040);
      rsv(1, 32'h0080, 0);
      set_sc(1, 0, 64'h1_0000_0000, 64'h84, 64'h2); tick(); idle();
      chk(mem_we && mem_addr == 32'h84, "R1 truncation", mem_addr, 32'h84);

      req = "R7"; rsv(2, 32'h3000, 0); sc(2, 32'h307C);
      chk(mem_we == 1, "R7 same line commits", mem_we, 1);
      rsv(2, 32'h3000, 0); sc(2, 32'h3080);

      req = "R5"; rsv(0, 32'h1000, 0); sc(0, 32'h1000); sc(0, 32'h1000);
      chk(cr_field[1] == 0, "R5 second sc fails", cr_field, 4'b0000);

      req = "R4"; so_in = 1; sc(0, 32'h1000); so_in = 0;
      chk(cr_field == 4'b0001, "R4 failure with SO", cr_field, 4'b0001);

      req = "R6"; rsv(3, 32'h2000, 1); sc(3, 32'h2000);

      req = "R8"; rsv(3, 32'h4000, 0); snoop(32'h407F); sc(3, 32'h4000);
      rsv(3, 32'h4000, 0); snoop(32'h4080); sc(3, 32'h4000);
      rsv(3, 32'h4000, 0);
      snoop_valid = 1; snoop_addr = 32'h4010; set_sc(3, 0, 0, 64'h4000, 64'h5); tick(); idle();
      set_rsv(3, 32'h4000, 0); snoop_valid = 1; snoop_addr = 32'h4000; tick(); idle();
      sc(3, 32'h4000);

      req = "R9"; rsv(0, 32'h5000, 0); sc(0, 32'h5002);
      chk(align_fault == 1 && mem_we == 0, "R9 fault", align_fault, 1);
      sc(0, 32'h5000);

      req = "R10"; rsv(0, 32'h6000, 0); rsv(1, 32'h6100, 0);
      ctx_clear = 4'b0001; tick(); idle();
      sc(0, 32'h6000); sc(1, 32'h6100);
      set_rsv(2, 32'h6200, 0); ctx_clear = 4'b0100; tick(); idle(); sc(2, 32'h6200);

      req = "R11"; rsv(0, 32'h7000, 0); rsv(0, 32'h7100, 0); sc(0, 32'h7000);
      rsv(0, 32'h7000, 0); set_rsv(0, 32'h7000, 0); set_sc(0, 0, 0, 64'h7000, 64'h9); tick(); idle();
      sc(0, 32'h7000);

      req = "R12"; rsv(0, 32'h8000, 0); rsv(1, 32'h8040, 0); rsv(2, 32'h9000, 0);
      sc(0, 32'h8000); sc(1, 32'h8040); sc(2, 32'h9000);
      chk(mem_we == 1, "R12 other line kept", mem_we, 1);

      req = "R8 random";
      for (int n = 0; n < 600; n++) begin
         if ($urandom_range(0, 2) == 0) set_rsv($urandom_range(0, 2), 32'hA000 + 4 * $urandom_range(0, 63), $urandom_range(0, 5) == 0);
         if ($urandom_range(0, 2) == 0)
            set_sc($urandom_range(0, 2), $urandom_range(0, 1), 64'hA000,
                   ($urandom_range(0, 1) ? 64'hA000 : 64'h0) + 4 * $urandom_range(0, 63) - ($urandom_range(0, 1) ? 64'hA000 : 64'h0)
                   + ($urandom_range(0, 9) == 0 ? 64'd1 : 64'd0),
                   {$urandom, $urandom});
         if ($urandom_range(0, 5) == 0) begin snoop_valid = 1; snoop_addr = 32'hA000 + $urandom_range(0, 255); end
         if ($urandom_range(0, 9) == 0) ctx_clear = 4'($urandom_range(0, 15));
         so_in = 1'($urandom_range(0, 1));
         tick(); idle();
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule